// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a single mouse event into a five-byte packet in the classic three-button serial mouse format. An event is a one-cycle strobe together with two signed 16-bit motion deltas and three button levels. The encoder captures the event and then offers the packet bytes, one per clock, to a receive byte queue that feeds a serial channel.

The first byte is a header. Its upper bits are a fixed start pattern, and each of its three low bits is cleared while its button is pressed. The second byte is the horizontal motion and the third is the vertical motion with its sign reversed. Each motion value is clamped to a symmetric range before it is truncated to eight bits. Two zero bytes close the packet.

The queue side has no back-pressure stall. A byte that the queue refuses is lost, and the packet moves on to its next byte. While a packet is in flight, the encoder raises a busy flag and ignores new events.

Top module: `mouse_packet_encoder`

## Requirements
- R1: After a synchronous reset, `outValid` and `busy` are 0.
- R2: The header byte is 0x87 with left clearing bit 2, middle clearing bit 1 and right clearing bit 0. All pressed gives 0x80 and none pressed gives 0x87.
- R3: The X byte is `moveX` clamped to the range -127..+127 and sent as 8-bit two's complement. 300 gives 0x7F, -32768 gives 0x81 and -128 gives 0x81.
- R4: The Y byte is the negation of `moveY`, clamped to -127..+127 and sent as 8-bit two's complement. 3 gives 0xFD, -300 gives 0x7F, -32768 gives 0x7F and 32767 gives 0x81.
- R5: The fourth and fifth bytes are always 0x00.
- R6: An accepted event (`evtValid` high while `busy` is low at a clock edge) produces `outValid` high on exactly the next five cycles. In those cycles the bytes appear in the order header, X, Y, 0, 0, and then `outValid` falls.
- R7: A byte offered while `outReady` is low is dropped. It is not offered again, and the next cycle carries the next byte of the packet.
- R8: `busy` is high for the five byte cycles. An event that arrives while `busy` is high, including in the final byte cycle, is ignored: the packet in flight is unchanged and no new packet follows.
- R9: Asserting reset in the middle of a packet abandons it. On the next cycle `outValid` and `busy` are 0, and no remaining byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | One-cycle strobe for a new mouse event |
| moveX | input | 16 | Signed horizontal motion |
| moveY | input | 16 | Signed vertical motion |
| btnLeft | input | 1 | Left button pressed |
| btnMiddle | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| outData | output | 8 | Packet byte offered to the queue |
| outValid | output | 1 | `outData` is offered this cycle |
| outReady | input | 1 | Queue can take the byte this cycle |
| busy | output | 1 | Packet in flight; new events ignored |

## Verification
Two functions can fall in the same cycle.

The first case is a new event that arrives in the final byte cycle of a packet. The bench raises `evtValid` exactly when the fifth byte is on the port. It then checks that `outValid` stays low over the following cycles, so that event did not start a second packet. An event raised in the first idle cycle must still start a packet, which confirms that the boundary falls where R6 puts it.

The second case is a queue refusal that lands on the X byte. The bench verifies that the following cycle offers the Y byte and not a repeated X.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_BYTES = 5;
  localparam int SEL_W = $clog2(PKT_BYTES);
  localparam logic [7:0] HDR_IDLE = 8'h87;

  typedef struct packed {
    logic             load;
    logic             emit;
    logic [SEL_W-1:0] sel;
  } mpe_strobe_t;
endpackage

// File: rtl/mpe_ctrl.sv
module mpe_ctrl
  import mpe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        evtValid,
  input  logic        outReady,
  output logic        busy,
  output mpe_strobe_t strobe
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(PKT_BYTES - 1);

  logic             active;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (!active) begin
      if (evtValid) begin
        active <= 1'b1;
        idx    <= '0;
      end
    end else if (idx == LAST) begin
      active <= 1'b0;
      idx    <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    strobe.load = evtValid && !active;
    strobe.emit = active;
    strobe.sel  = idx;
  end

  assign busy = active;

  assert_len_R6: assert property (@(posedge clk) disable iff (rst)
    (active && idx == LAST) |=> !busy);

  assert_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(evtValid));

  assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (active && idx != LAST && !outReady) |=> (busy && idx == $past(idx) + 1'b1));

  assert_abandon_R9: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int LIMIT   = 127
) (
  input  logic               clk,
  input  logic               rst,
  input  mpe_strobe_t        strobe,
  input  logic [DELTA_W-1:0] moveX,
  input  logic [DELTA_W-1:0] moveY,
  input  logic [2:0]         btns,
  output logic [7:0]         outData,
  output logic               outValid
);
  localparam int EXT_W = DELTA_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(LIMIT);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -EXT_W'(LIMIT);

  function automatic logic [7:0] clampByte(input logic signed [EXT_W-1:0] v);
    if (v > POS_LIM)      return POS_LIM[7:0];
    else if (v < NEG_LIM) return NEG_LIM[7:0];
    else                  return v[7:0];
  endfunction

  logic signed [EXT_W-1:0] xExt, yNeg;
  logic [7:0] hdrReg, xReg, yReg;

  always_comb begin
    xExt = $signed({moveX[DELTA_W-1], moveX});
    yNeg = -$signed({moveY[DELTA_W-1], moveY});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrReg <= HDR_IDLE;
      xReg   <= '0;
      yReg   <= '0;
    end else if (strobe.load) begin
      hdrReg <= HDR_IDLE ^ {5'b0, btns};
      xReg   <= clampByte(xExt);
      yReg   <= clampByte(yNeg);
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_W'(0): outData = hdrReg;
      SEL_W'(1): outData = xReg;
      SEL_W'(2): outData = yReg;
      default:   outData = 8'h00;
    endcase
  end

  assign outValid = strobe.emit;

  assert_header_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && strobe.sel == SEL_W'(0)) |-> outData[7:3] == 5'b10000);

  assert_xsat_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && strobe.sel == SEL_W'(1)) |-> outData != 8'h80);

  assert_ysat_R4: assert property (@(posedge clk) disable iff (rst)
    (outValid && strobe.sel == SEL_W'(2)) |-> outData != 8'h80);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> ($stable(hdrReg) && $stable(xReg) && $stable(yReg)));
endmodule

// File: rtl/mouse_packet_encoder.sv
module mouse_packet_encoder
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int LIMIT   = 127
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evtValid,
  input  logic [DELTA_W-1:0] moveX,
  input  logic [DELTA_W-1:0] moveY,
  input  logic               btnLeft,
  input  logic               btnMiddle,
  input  logic               btnRight,
  output logic [7:0]         outData,
  output logic               outValid,
  input  logic               outReady,
  output logic               busy
);
  mpe_strobe_t strobe;

  mpe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .evtValid (evtValid),
    .outReady (outReady),
    .busy     (busy),
    .strobe   (strobe)
  );

  mpe_datapath #(.DELTA_W(DELTA_W), .LIMIT(LIMIT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .moveX    (moveX),
    .moveY    (moveY),
    .btns     ({btnLeft, btnMiddle, btnRight}),
    .outData  (outData),
    .outValid (outValid)
  );
endmodule

// File: tb/mouse_packet_encoder_tb.sv
module mouse_packet_encoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evtValid = 1'b0;
  logic [15:0] moveX = '0, moveY = '0;
  logic btnLeft = 1'b0, btnMiddle = 1'b0, btnRight = 1'b0;
  logic outReady = 1'b1;
  logic [7:0] outData;
  logic outValid, busy;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mouse_packet_encoder u_dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .moveX(moveX), .moveY(moveY),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .outData(outData), .outValid(outValid), .outReady(outReady), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] clampRef(input int v);
    int c;
    c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return c[7:0];
  endfunction

  // drive event at a negedge; following negedge shows byte 0
  task automatic fireEvent(input int dx, input int dy, input logic l, m, r);
    @(negedge clk);
    moveX = dx[15:0]; moveY = dy[15:0];
    btnLeft = l; btnMiddle = m; btnRight = r;
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic checkPacket(input string tag, input int dx, input int dy,
                             input logic l, m, r);
    logic [7:0] exp [5];
    exp[0] = 8'h87 ^ {5'b0, l, m, r};
    exp[1] = clampRef(dx);
    exp[2] = clampRef(-dy);
    exp[3] = 8'h00;
    exp[4] = 8'h00;
    fireEvent(dx, dy, l, m, r);
    for (int i = 0; i < 5; i++) begin
      chk({tag, " R6 valid"}, {31'b0, outValid}, 32'd1);
      chk({tag, " R8 busy"}, {31'b0, busy}, 32'd1);
      chk({tag, " byte"}, {24'b0, outData}, {24'b0, exp[i]});
      @(negedge clk);
    end
    chk({tag, " R6 end"}, {31'b0, outValid}, 32'd0);
    chk({tag, " R8 idle"}, {31'b0, busy}, 32'd0);
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid", {31'b0, outValid}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
  endtask

  task automatic testBasic;
    checkPacket("R2 R5 basic", 5, 3, 0, 0, 0);
    checkPacket("R2 left", 0, 0, 1, 0, 0);
    checkPacket("R2 middle", 1, -1, 0, 1, 0);
    checkPacket("R2 right", -2, 2, 0, 0, 1);
    checkPacket("R2 all", 10, 10, 1, 1, 1);
  endtask

  task automatic testSaturate;
    checkPacket("R3 R4 big", 300, -300, 0, 0, 0);
    checkPacket("R3 R4 extreme", -32768, -32768, 0, 0, 0);
    checkPacket("R3 R4 edge", 127, 32767, 0, 0, 0);
    checkPacket("R3 R4 edge2", -128, 128, 0, 0, 0);
    checkPacket("R3 R4 edge3", -127, 127, 0, 0, 0);
  endtask

  task automatic testDrop;
    fireEvent(40, 20, 0, 0, 0);
    chk("R7 hdr", {24'b0, outData}, 32'h87);
    outReady = 1'b0;
    @(negedge clk);
    chk("R7 x offered", {24'b0, outData}, 32'h28);
    outReady = 1'b1;
    @(negedge clk);
    chk("R7 next is y", {24'b0, outData}, {24'b0, 8'hEC});
    chk("R7 valid", {31'b0, outValid}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R7 last zero", {24'b0, outData}, 32'h00);
    @(negedge clk);
    chk("R7 done", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testBusyIgnore;
    fireEvent(7, 0, 0, 0, 0);
    @(negedge clk);
    moveX = 16'd99; btnLeft = 1'b1; evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    chk("R8 y unchanged", {24'b0, outData}, 32'h00);
    @(negedge clk);
    @(negedge clk);
    chk("R8 final cycle busy", {31'b0, busy}, 32'd1);
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 no new packet", {31'b0, outValid}, 32'd0);
      @(negedge clk);
    end
    // event in first idle cycle is accepted
    checkPacket("R6 idle accept", 3, 0, 0, 0, 0);
    evtValid = 1'b1; moveX = 16'd1; moveY = 16'd0;
    btnLeft = 1'b0; btnMiddle = 1'b0; btnRight = 1'b0;
    @(negedge clk);
    evtValid = 1'b0;
    chk("R6 back to back", {24'b0, outData}, 32'h87);
    repeat (5) @(negedge clk);
  endtask

  task automatic testMidReset;
    fireEvent(9, 9, 1, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 valid", {31'b0, outValid}, 32'd0);
    chk("R9 busy", {31'b0, busy}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no resume", {31'b0, outValid}, 32'd0);
    end
  endtask

  initial begin
    testReset();
    testBasic();
    testSaturate();
    testDrop();
    testBusyIgnore();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule